// File: doc/BRIEF.md
# External Destination Address Matcher

This block sits beside a MAC's receive path and listens to its address-detection tap. The tap gives a receive clock and either a serial data bit or a 4-bit nibble. It also gives a strobe that is first raised when the start-of-frame delimiter is seen and then changes level at every following byte boundary. The block oversamples these tap signals in its own system clock domain. It builds bytes from the data and uses the strobe edges, not a local bit counter, to tell where each byte ends. From the first six bytes it forms the 48-bit destination address.

The address is compared at once against a small table of programmed entries, each with a valid flag. If no valid entry holds that address, the block drives an active-low reject output low for a fixed minimum time, so that the MAC drops the frame. If an entry matches, or the frame ends before six bytes have arrived, the reject output stays high. The pulse width is derived from the system clock period, so the low time never falls short of 110 ns. The pulse is issued right after the sixth byte, which is within the deadline in both cases: 8 bytes when runt frames are accepted and 64 bytes otherwise.

The control state machine has six states. ST_IDLE waits for receive activity. ST_ARM waits for the first strobe rise. ST_COLLECT gathers the address bytes. ST_DECIDE makes the one-cycle table decision. ST_PULSE holds reject low. ST_DONE waits for the end of the frame. The transitions are:
- ST_IDLE to ST_ARM when `rx_active` rises.
- ST_ARM to ST_COLLECT on the first strobe rise.
- ST_ARM to ST_IDLE, and ST_COLLECT to ST_IDLE, when activity ends.
- ST_COLLECT to ST_DECIDE when the sixth byte is latched.
- ST_DECIDE to ST_DONE on a hit, or to ST_PULSE on a miss.
- ST_PULSE to ST_DONE when the width counter expires.
- ST_DONE to ST_IDLE when activity ends.

Top module: `ext_addr_matcher`

## Requirements
- R1: After reset, `reject_n` is 1 and `dest_addr` is 0.
- R2: While `rx_active` is high, the first rising edge of `byte_strobe` starts the frame and is not itself a byte boundary. Every later edge of `byte_strobe`, rising or falling, latches the byte assembled so far.
- R3: With `mii_mode` = 0, one bit of `tap_bit` is taken at each rising edge of `tap_clk`. The first bit received becomes bit 0 of its byte.
- R4: With `mii_mode` = 1, one nibble of `tap_nib` is taken at each rising edge of `tap_clk`. The first nibble becomes bits 3:0 of its byte and the second becomes bits 7:4.
- R5: When the sixth byte is latched, `dest_addr` loads the six bytes with the first byte in bits 47:40 and the sixth in bits 7:0. It holds that value until the next frame completes its sixth byte.
- R6: The table is written through `tbl_we`, `tbl_idx`, `tbl_addr` and `tbl_valid` in one clock. A frame whose address equals a valid entry produces no reject pulse.
- R7: An entry whose valid flag is 0 never matches, even when its stored address equals the frame's address, so such a frame is rejected.
- R8: A rejected frame drives `reject_n` low for exactly PULSE_CYCLES = ceil(MIN_LOW_PS / CLK_PERIOD_PS) system clocks. With the defaults this is 28.
- R9: `reject_n` is high between frames and while the address bytes are still being collected. It goes low at most once per frame, and only after the sixth byte.
- R10: The reject pulse begins before 8 bytes have been received when `runt_ok` = 1, and before 64 bytes when `runt_ok` = 0.
- R11: A frame that ends with fewer than six bytes latched produces no reject and leaves `dest_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the tap |
| rst_n | input | 1 | Asynchronous active-low reset |
| mii_mode | input | 1 | 1 = nibble tap, 0 = serial bit tap |
| runt_ok | input | 1 | 1 = MAC accepts runt frames (8-byte deadline) |
| tap_clk | input | 1 | Receive clock from the tap |
| tap_bit | input | 1 | Serial receive data |
| tap_nib | input | 4 | Receive nibble in nibble mode |
| byte_strobe | input | 1 | Frame start and byte boundary strobe |
| rx_active | input | 1 | High while a frame is being received |
| tbl_we | input | 1 | Table write enable |
| tbl_idx | input | IDX_W (2) | Table entry selected for the write |
| tbl_addr | input | 48 | Address written into the entry |
| tbl_valid | input | 1 | Valid flag written into the entry |
| reject_n | output | 1 | Active-low reject to the MAC |
| dest_addr | output | 48 | Last captured destination address |

## Verification
The bench keeps the default parameters: four table entries, two synchronizer stages and a 4 ns system clock. Against the 110 ns minimum, that clock gives a 28-cycle reject pulse, whose exact width is measured. The tap clock runs at 40 ns, so each tap event spans ten system cycles. Strobe edges and data edges are then cleanly separated after synchronization, and the bench can note which byte boundary was the last one sent when reject fell. With four entries, the bench can program a hit in a first and a last slot, leave one slot invalid but holding a live address, and overwrite another slot between frames.

// File: rtl/eadm_pkg.sv
package eadm_pkg;
    localparam int ADDR_W        = 48;
    localparam int DA_BYTES      = 6;
    localparam int LONG_DEADLINE = 64;
    localparam int RUNT_DEADLINE = 8;
    localparam int CNT_W         = $clog2(LONG_DEADLINE + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_COLLECT,
        ST_DECIDE,
        ST_PULSE,
        ST_DONE
    } ctrl_state_t;
endpackage

// File: rtl/eadm_tap_sync.sv
module eadm_tap_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/eadm_byte_asm.sv
module eadm_byte_asm
    import eadm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              mii_mode,
    input  logic              tick,
    input  logic              bit_in,
    input  logic [3:0]        nib_in,
    input  logic              byte_edge,
    output logic [CNT_W-1:0]  byte_cnt,
    output logic              da_done,
    output logic [ADDR_W-1:0] dest_q
);
    localparam int ACC_W = (DA_BYTES - 1) * 8;

    logic [7:0]       sh;
    logic [ACC_W-1:0] acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh       <= '0;
            acc      <= '0;
            byte_cnt <= '0;
            da_done  <= 1'b0;
            dest_q   <= '0;
        end else begin
            da_done <= 1'b0;
            if (!enable) begin
                sh       <= '0;
                acc      <= '0;
                byte_cnt <= '0;
            end else begin
                if (tick) begin
                    // first arrival ends up in the low end of the byte
                    if (mii_mode) sh <= {nib_in, sh[7:4]};
                    else          sh <= {bit_in, sh[7:1]};
                end
                if (byte_edge) begin
                    acc <= {acc[ACC_W-9:0], sh};
                    if (byte_cnt == CNT_W'(DA_BYTES - 1)) begin
                        dest_q  <= {acc, sh};
                        da_done <= 1'b1;
                    end
                    if (byte_cnt != CNT_W'(LONG_DEADLINE)) begin
                        byte_cnt <= byte_cnt + 1'b1;
                    end
                end
            end
        end
    end

    AST_DEST_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(dest_q)); // R11
endmodule

// File: rtl/eadm_addr_table.sv
module eadm_addr_table
    import eadm_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] key,
    output logic              hit
);
    logic [NUM_ENTRIES-1:0] match;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
        logic [ADDR_W-1:0] ent_addr;
        logic              ent_valid;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_addr  <= '0;
                ent_valid <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                ent_addr  <= wr_addr;
                ent_valid <= wr_valid;
            end
        end

        assign match[g] = ent_valid && (ent_addr == key);
    end

    assign hit = |match;
endmodule

// File: rtl/eadm_ctrl.sv
module eadm_ctrl
    import eadm_pkg::*;
#(
    parameter int PULSE_CYCLES = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_active,
    input  logic             strobe_rise,
    input  logic             da_done,
    input  logic             hit,
    input  logic             runt_ok,
    input  logic [CNT_W-1:0] byte_cnt,
    output logic             enable,
    output logic             reject_n
);
    localparam int PW = $clog2(PULSE_CYCLES + 1);
    localparam int LW = $clog2(PULSE_CYCLES + 2);

    ctrl_state_t state, state_nx;
    logic [PW-1:0] pulse_cnt;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (rx_active) state_nx = ST_ARM;
            ST_ARM: begin
                if (!rx_active)       state_nx = ST_IDLE;
                else if (strobe_rise) state_nx = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (!rx_active)   state_nx = ST_IDLE;
                else if (da_done) state_nx = ST_DECIDE;
            end
            ST_DECIDE:  state_nx = hit ? ST_DONE : ST_PULSE;
            ST_PULSE:   if (pulse_cnt == PW'(PULSE_CYCLES - 1)) state_nx = ST_DONE;
            ST_DONE:    if (!rx_active) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reject_n  <= 1'b1;
            pulse_cnt <= '0;
        end else begin
            reject_n  <= (state_nx != ST_PULSE);
            pulse_cnt <= (state == ST_PULSE) ? pulse_cnt + 1'b1 : '0;
        end
    end

    assign enable = (state == ST_COLLECT) || (state == ST_DECIDE) ||
                    (state == ST_PULSE)   || (state == ST_DONE);

    // measures the low run of reject_n independently of pulse_cnt
    logic [LW-1:0] low_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          low_len <= '0;
        else if (reject_n)                   low_len <= '0;
        else if (low_len != LW'(PULSE_CYCLES + 1)) low_len <= low_len + 1'b1;
    end

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reject_n) |-> (low_len == LW'(PULSE_CYCLES))); // R8
    AST_NO_EARLY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reject_n) |-> (byte_cnt >= CNT_W'(DA_BYTES))); // R9
    AST_DEADLINE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reject_n) |-> (byte_cnt < (runt_ok ? CNT_W'(RUNT_DEADLINE)
                                                 : CNT_W'(LONG_DEADLINE)))); // R10
    AST_HIT_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECIDE && hit) |=> reject_n); // R6
endmodule

// File: rtl/ext_addr_matcher.sv
module ext_addr_matcher
    import eadm_pkg::*;
#(
    parameter int NUM_ENTRIES   = 4,
    parameter int IDX_W         = $clog2(NUM_ENTRIES),
    parameter int SYNC_STAGES   = 2,
    parameter int CLK_PERIOD_PS = 4000,
    parameter int MIN_LOW_PS    = 110000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mii_mode,
    input  logic              runt_ok,
    input  logic              tap_clk,
    input  logic              tap_bit,
    input  logic [3:0]        tap_nib,
    input  logic              byte_strobe,
    input  logic              rx_active,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic [47:0]       tbl_addr,
    input  logic              tbl_valid,
    output logic              reject_n,
    output logic [47:0]       dest_addr
);
    localparam int PULSE_CYCLES = (MIN_LOW_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int TAP_W        = 8;

    logic [TAP_W-1:0] tap_raw, tap_s;
    logic tclk_s, tbit_s, str_s, act_s;
    logic [3:0] tnib_s;
    logic tclk_p, str_p;
    logic tick, byte_edge, strobe_rise;
    logic enable, da_done, hit;
    logic [CNT_W-1:0] byte_cnt;

    assign tap_raw = {tap_clk, tap_bit, tap_nib, byte_strobe, rx_active};

    eadm_tap_sync #(.WIDTH(TAP_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (tap_raw),
        .q    (tap_s)
    );

    assign {tclk_s, tbit_s, tnib_s, str_s, act_s} = tap_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tclk_p <= 1'b0;
            str_p  <= 1'b0;
        end else begin
            tclk_p <= tclk_s;
            str_p  <= str_s;
        end
    end

    assign tick        = tclk_s & ~tclk_p;
    assign byte_edge   = str_s ^ str_p;
    assign strobe_rise = str_s & ~str_p;

    eadm_byte_asm u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .mii_mode (mii_mode),
        .tick     (tick),
        .bit_in   (tbit_s),
        .nib_in   (tnib_s),
        .byte_edge(byte_edge),
        .byte_cnt (byte_cnt),
        .da_done  (da_done),
        .dest_q   (dest_addr)
    );

    eadm_addr_table #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we),
        .wr_idx  (tbl_idx),
        .wr_addr (tbl_addr),
        .wr_valid(tbl_valid),
        .key     (dest_addr),
        .hit     (hit)
    );

    eadm_ctrl #(.PULSE_CYCLES(PULSE_CYCLES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_active  (act_s),
        .strobe_rise(strobe_rise),
        .da_done    (da_done),
        .hit        (hit),
        .runt_ok    (runt_ok),
        .byte_cnt   (byte_cnt),
        .enable     (enable),
        .reject_n   (reject_n)
    );
endmodule

// File: tb/ext_addr_matcher_tb_top.sv
module ext_addr_matcher_tb_top;
    localparam int PULSE = (110000 + 4000 - 1) / 4000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mii_mode = 1'b0, runt_ok = 1'b0;
    logic tap_clk = 1'b0, tap_bit = 1'b0, byte_strobe = 1'b0, rx_active = 1'b0;
    logic [3:0] tap_nib = '0;
    logic tbl_we = 1'b0, tbl_valid = 1'b0;
    logic [1:0] tbl_idx = '0;
    logic [47:0] tbl_addr = '0;
    logic reject_n;
    logic [47:0] dest_addr;

    always #2 clk = ~clk;

    ext_addr_matcher dut_i (
        .clk(clk), .rst_n(rst_n), .mii_mode(mii_mode), .runt_ok(runt_ok),
        .tap_clk(tap_clk), .tap_bit(tap_bit), .tap_nib(tap_nib),
        .byte_strobe(byte_strobe), .rx_active(rx_active),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_addr(tbl_addr), .tbl_valid(tbl_valid),
        .reject_n(reject_n), .dest_addr(dest_addr)
    );

    typedef struct {
        logic [47:0] da;
        bit          rej;
        bit          full;
        bit          runt;
        string       tag_rej;
        string       tag_da;
    } exp_t;

    exp_t q[$];
    int checks = 0, errors = 0;
    int sent_bytes = 0;
    bit end_req = 1'b0;
    bit done = 1'b0;
    logic [47:0] last_da = '0;

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic wr_entry(int idx, logic [47:0] a, bit v);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = 2'(idx); tbl_addr = a; tbl_valid = v;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // driver: pushes the expected outcome, then plays the frame on the tap
    task automatic send_frame(logic [47:0] da, int nb, bit exp_rej,
                              string tag_rej, string tag_da);
        exp_t e;
        logic [7:0] b;
        int units;
        e.da = da; e.rej = exp_rej; e.full = (nb >= 6); e.runt = runt_ok;
        e.tag_rej = tag_rej; e.tag_da = tag_da;
        q.push_back(e);
        units = mii_mode ? 2 : 8;
        @(negedge clk);
        sent_bytes = 0;
        rx_active = 1'b1;
        #20;
        for (int i = 0; i < nb; i++) begin
            b = (i < 6) ? da[47-8*i -: 8] : 8'(8'hA0 + i);
            for (int u = 0; u < units; u++) begin
                if (u == 0) begin
                    if (i == 0) byte_strobe = 1'b1;
                    else begin byte_strobe = ~byte_strobe; sent_bytes = i; end
                end
                if (mii_mode) tap_nib = b[4*u +: 4];
                else          tap_bit = b[u];
                #20 tap_clk = 1'b1;
                #20 tap_clk = 1'b0;
            end
        end
        byte_strobe = ~byte_strobe;
        sent_bytes = nb;
        #400;
        rx_active = 1'b0;
        byte_strobe = 1'b0;
        #100;
        end_req = 1'b1;
        wait (!end_req);
    endtask

    // monitor: observes reject_n and compares at the end of each frame
    initial begin
        bit seen = 1'b0;
        int low_cnt = 0, fall_byte = 0;
        exp_t e;
        logic [47:0] exp_da;
        forever begin
            @(negedge clk);
            if (rst_n && !reject_n) begin
                if (!seen) begin seen = 1'b1; fall_byte = sent_bytes; end
                low_cnt++;
            end
            if (end_req) begin
                e = q.pop_front();
                chk(seen == e.rej, e.tag_rej, 64'(seen), 64'(e.rej));
                if (e.rej) begin
                    chk(low_cnt == PULSE, "R8 pulse width", 64'(low_cnt), 64'(PULSE));
                    chk(fall_byte >= 6, "R9 reject after address", 64'(fall_byte), 64'd6);
                    chk(fall_byte < (e.runt ? 8 : 64), "R10 deadline",
                        64'(fall_byte), e.runt ? 64'd8 : 64'd64);
                end
                exp_da = e.full ? e.da : last_da;
                chk(dest_addr == exp_da, e.tag_da, 64'(dest_addr), 64'(exp_da));
                if (e.full) last_da = e.da;
                chk(reject_n == 1'b1, "R9 high between frames", 64'(reject_n), 64'd1);
                seen = 1'b0; low_cnt = 0;
                end_req = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        report();
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(reject_n == 1'b1, "R1 reject_n reset", 64'(reject_n), 64'd1);
        chk(dest_addr == 48'h0, "R1 dest_addr reset", 64'(dest_addr), 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        wr_entry(0, 48'h0123_4567_89AB, 1'b1);
        wr_entry(3, 48'hC2D4_E6F8_1A3B, 1'b1);
        wr_entry(2, 48'h5E5E_1234_0F0F, 1'b0);

        mii_mode = 1'b0; runt_ok = 1'b0;
        send_frame(48'h0123_4567_89AB, 8, 1'b0, "R6 serial hit slot0", "R2/R3/R5 serial address");
        send_frame(48'h8001_0203_0405, 8, 1'b1, "R6 serial miss rejects", "R3/R5 serial address");

        mii_mode = 1'b1;
        send_frame(48'hC2D4_E6F8_1A3B, 8, 1'b0, "R6 nibble hit slot3", "R4/R5 nibble address");
        runt_ok = 1'b1;
        send_frame(48'h7A6B_5C4D_3E2F, 8, 1'b1, "R6 nibble miss rejects", "R4 nibble address");
        send_frame(48'h5E5E_1234_0F0F, 8, 1'b1, "R7 invalid entry ignored", "R4/R5 address");

        mii_mode = 1'b0; runt_ok = 1'b0;
        send_frame(48'h0123_4567_89AB, 4, 1'b0, "R11 short frame no reject", "R11 address unchanged");

        wr_entry(1, 48'hF0E1_D2C3_B4A5, 1'b1);
        send_frame(48'hF0E1_D2C3_B4A5, 8, 1'b0, "R6 rewritten slot1 hit", "R3/R5 serial address");
        wr_entry(1, 48'hF0E1_D2C3_B4A5, 1'b0);
        mii_mode = 1'b1;
        send_frame(48'hF0E1_D2C3_B4A5, 8, 1'b1, "R7 cleared slot1 misses", "R2/R4 nibble address");

        repeat (10) @(negedge clk);
        report();
    end
endmodule